// File: doc/BRIEF.md
# Charger Identification Switch Controller

This block is the digital control logic behind a USB port data-line switch that lets a host port present itself as a charger. It chooses which of three analog paths is connected to the connector's D+ and D- lines: pass-through to the USB transceiver, a direct D+/D- short, or a resistor-divider bias. It also decides whether the supply for the on-chip divider is powered. Two mode-select bits pick a forced path or automatic detection. Three comparator flags report the line conditions: DM above the high threshold (about 2.1 V), DM above the low threshold (about 0.35 V), and the bias-select pin above its threshold (about 0.4 V), which means external resistors are fitted.

In automatic mode a state machine first applies the bias. If DM then settles between the two thresholds, it shorts the lines. If DM drops below the low threshold while shorted, it restores the bias. Comparator flags pass through debouncers counted in clock cycles, and mode bits pass through a two-flop synchronizer. The output stage guarantees break-before-make between paths.

States: `ST_AUTO_BIAS`, `ST_AUTO_SHORT`, `ST_FORCE_SHORT`, `ST_FORCE_BIAS`, `ST_PASS`. Transitions:
- Any state to the matching forced or pass state when the synchronized mode is not automatic.
- Any non-automatic state to `ST_AUTO_BIAS` when the mode returns to automatic.
- `ST_AUTO_BIAS` to `ST_AUTO_SHORT` on DM below high and above low.
- `ST_AUTO_SHORT` to `ST_AUTO_BIAS` on DM below low.

Top module: `chgid_ctrl`

## Requirements
- R1: Mode code 2'b01 selects the short path, 2'b10 selects the bias path and 2'b11 selects pass-through, whatever the comparator flags say. The mode code is `mode_sel[1:0]`.
- R2: Reset, and every return of the mode code to 2'b00, places the controller in the automatic bias state (status 2'b00, bias path on). The automatic state is reported as bias on the third clock after the mode input changes.
- R3: In the automatic bias state, a debounced DM that is below the high threshold but still above the low threshold moves the controller to the automatic short state. DM below both thresholds leaves the bias connected.
- R4: In the automatic short state, a debounced DM below the low threshold restores the bias. While DM stays at or above the high threshold, the bias state is kept.
- R5: A comparator change takes effect only after it has persisted for DEB_TICKS consecutive clocks. A shorter excursion has no effect on status or paths, and a held change has not yet taken effect after DEB_TICKS-1 clocks.
- R6: While the debounced bias-select flag is high (external resistors), `div_sup_en` is low in every mode.
- R7: `div_sup_en` is high only while the bias path is enabled and the bias-select flag is low. It is low in pass-through and short.
- R8: At most one path enable is high at any time. A change of path goes through exactly one clock with all enables low: the new path turns on two clocks after the status changes, with all enables low on the clock in between.
- R9: A change of the mode code away from 2'b00 leaves automatic detection on the third clock after the input change, even from the automatic short state.
- R10: `status` encodes the commanded path: 2'b00 bias, 2'b01 short, 2'b10 pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Mode code (00 auto, 01 short, 10 bias, 11 pass) |
| dm_above_hi | input | 1 | DM above high threshold flag |
| dm_above_lo | input | 1 | DM above low threshold flag |
| bsel_above | input | 1 | Bias-select pin above threshold (external resistors) |
| en_pass | output | 1 | Pass-through path enable |
| en_short | output | 1 | D+/D- short enable |
| en_bias | output | 1 | Resistor bias path enable |
| div_sup_en | output | 1 | Internal divider supply enable |
| status | output | 2 | Commanded path code |

## Verification
Several properties are checked on every cycle: the one-hot rule for the path enables, the rule that a path change passes through an all-off clock, the bond between the divider supply enable, the bias path and the external-resistor flag, and the rule that a forced mode sets the state on the next clock. Other behaviour shows only in the bench's scenarios: the automatic detection sequence through both thresholds, rejection of comparator glitches shorter than the debounce window, the exact clock on which a held change takes effect, and the restart into bias when automatic mode is selected again while DM still favours the short.

// File: rtl/chgid_pkg.sv
package chgid_pkg;

    typedef enum logic [2:0] {
        ST_AUTO_BIAS   = 3'd0,
        ST_AUTO_SHORT  = 3'd1,
        ST_FORCE_SHORT = 3'd2,
        ST_FORCE_BIAS  = 3'd3,
        ST_PASS        = 3'd4
    } chg_state_e;

    typedef enum logic [1:0] {
        PATH_BIAS  = 2'b00,
        PATH_SHORT = 2'b01,
        PATH_PASS  = 2'b10,
        PATH_NONE  = 2'b11
    } path_e;

    localparam logic [1:0] MODE_AUTO  = 2'b00;
    localparam logic [1:0] MODE_SHORT = 2'b01;
    localparam logic [1:0] MODE_BIAS  = 2'b10;
    localparam logic [1:0] MODE_PASS  = 2'b11;

    // enable vector layout: {bias, short, pass}
    localparam int EN_W = 3;

    function automatic logic [EN_W-1:0] path_onehot(input path_e p);
        logic [EN_W-1:0] v;
        unique case (p)
            PATH_BIAS:  v = 3'b100;
            PATH_SHORT: v = 3'b010;
            PATH_PASS:  v = 3'b001;
            default:    v = 3'b000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/chgid_sync.sv
module chgid_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/chgid_debounce.sv
module chgid_debounce #(
    parameter int   TICKS   = 10000,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic stable
);

    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            stable <= RST_VAL;
        end else if (raw != stable) begin
            if (cnt == LAST) begin
                stable <= raw;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/chgid_fsm.sv
module chgid_fsm
    import chgid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_s,
    input  logic       dm_hi_d,
    input  logic       dm_lo_d,
    output path_e      want,
    output logic [1:0] status
);

    chg_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_AUTO_BIAS;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (mode_s)
            MODE_SHORT: nxt = ST_FORCE_SHORT;
            MODE_BIAS:  nxt = ST_FORCE_BIAS;
            MODE_PASS:  nxt = ST_PASS;
            default: begin
                unique case (state)
                    ST_AUTO_BIAS:
                        if (!dm_hi_d && dm_lo_d) nxt = ST_AUTO_SHORT;
                    ST_AUTO_SHORT:
                        if (!dm_lo_d) nxt = ST_AUTO_BIAS;
                    default:
                        nxt = ST_AUTO_BIAS;
                endcase
            end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_AUTO_BIAS, ST_FORCE_BIAS:   want = PATH_BIAS;
            ST_AUTO_SHORT, ST_FORCE_SHORT: want = PATH_SHORT;
            ST_PASS:                       want = PATH_PASS;
            default:                       want = PATH_BIAS;
        endcase
        status = want;
    end

endmodule

// File: rtl/chgid_path_drv.sv
module chgid_path_drv
    import chgid_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  path_e           want,
    input  logic            ext_bias,
    output logic [EN_W-1:0] en,
    output logic            sup_en
);

    logic [EN_W-1:0] target;

    assign target = path_onehot(want);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= path_onehot(PATH_BIAS);
        end else if (|en && (en != target)) begin
            en <= '0;
        end else if (en == '0) begin
            en <= target;
        end
    end

    assign sup_en = en[2] & ~ext_bias;

endmodule

// File: rtl/chgid_ctrl.sv
module chgid_ctrl
    import chgid_pkg::*;
#(
    parameter int DEB_TICKS   = 10000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       dm_above_hi,
    input  logic       dm_above_lo,
    input  logic       bsel_above,
    output logic       en_pass,
    output logic       en_short,
    output logic       en_bias,
    output logic       div_sup_en,
    output logic [1:0] status
);

    localparam int          NFLAG     = 3;
    localparam logic [NFLAG-1:0] FLAG_RST = 3'b011; // {bsel, dm_lo, dm_hi}

    logic [1:0]       mode_s;
    logic [NFLAG-1:0] flag_raw;
    logic [NFLAG-1:0] flag_d;
    logic             dm_hi_d, dm_lo_d, bsel_d;
    path_e            want;
    logic [EN_W-1:0]  en;

    chgid_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(MODE_AUTO)) u_mode_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mode_sel),
        .q     (mode_s)
    );

    assign flag_raw = {bsel_above, dm_above_lo, dm_above_hi};

    genvar i;
    generate
        for (i = 0; i < NFLAG; i++) begin : g_deb
            chgid_debounce #(.TICKS(DEB_TICKS), .RST_VAL(FLAG_RST[i])) u_deb (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw    (flag_raw[i]),
                .stable (flag_d[i])
            );
        end
    endgenerate

    assign dm_hi_d = flag_d[0];
    assign dm_lo_d = flag_d[1];
    assign bsel_d  = flag_d[2];

    chgid_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_s  (mode_s),
        .dm_hi_d (dm_hi_d),
        .dm_lo_d (dm_lo_d),
        .want    (want),
        .status  (status)
    );

    chgid_path_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .ext_bias (bsel_d),
        .en       (en),
        .sup_en   (div_sup_en)
    );

    assign en_bias  = en[2];
    assign en_short = en[1];
    assign en_pass  = en[0];

endmodule

// File: rtl/chgid_ctrl_chk.sv
module chgid_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_s,
    input logic       bsel_d,
    input logic       en_pass,
    input logic       en_short,
    input logic       en_bias,
    input logic       div_sup_en,
    input logic [1:0] status
);

    logic [2:0] paths;
    assign paths = {en_bias, en_short, en_pass};

    assert_paths_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(paths));

    assert_break_before_make_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|paths) |=> ((paths == $past(paths)) || (paths == 3'b000)));

    assert_supply_needs_bias_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_sup_en |-> en_bias);

    assert_supply_off_external_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bsel_d |-> !div_sup_en);

    assert_pass_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s == 2'b11) |=> (status == 2'b10));

    assert_forced_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s == 2'b01) |=> (status == 2'b01));

    assert_forced_bias_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s == 2'b10) |=> (status == 2'b00));

endmodule

bind chgid_ctrl chgid_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_s     (mode_s),
    .bsel_d     (bsel_d),
    .en_pass    (en_pass),
    .en_short   (en_short),
    .en_bias    (en_bias),
    .div_sup_en (div_sup_en),
    .status     (status)
);

// File: tb/chgid_ctrl_test.sv
module chgid_ctrl_test;

    localparam int DEB    = 8;
    localparam int SETTLE = DEB + 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       dm_above_hi = 1'b1;
    logic       dm_above_lo = 1'b1;
    logic       bsel_above = 1'b0;
    logic       en_pass, en_short, en_bias, div_sup_en;
    logic [1:0] status;

    int n_cmp = 0;
    int n_bad = 0;
    int bbm_viol = 0;
    int gap_seen = 0;
    logic [2:0] prev_paths = 3'b000;

    typedef struct {
        string      tag;
        logic [1:0] st;
        logic [2:0] paths;
        logic       sup;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    chgid_ctrl #(.DEB_TICKS(DEB)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .dm_above_hi (dm_above_hi),
        .dm_above_lo (dm_above_lo),
        .bsel_above  (bsel_above),
        .en_pass     (en_pass),
        .en_short    (en_short),
        .en_bias     (en_bias),
        .div_sup_en  (div_sup_en),
        .status      (status)
    );

    // monitor: compares queued expectations, tracks path switching
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                logic [2:0] cur;
                cur = {en_bias, en_short, en_pass};
                if ($countones(cur) > 1) bbm_viol++;
                if (prev_paths != 3'b000 && cur != 3'b000 && cur != prev_paths) bbm_viol++;
                if (prev_paths != 3'b000 && cur == 3'b000) gap_seen++;
                prev_paths = cur;
            end
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (status !== e.st || {en_bias, en_short, en_pass} !== e.paths
                    || div_sup_en !== e.sup) begin
                    n_bad++;
                    $display("FAIL %s: got status=%b paths=%b sup=%b, expected status=%b paths=%b sup=%b",
                             e.tag, status, {en_bias, en_short, en_pass}, div_sup_en,
                             e.st, e.paths, e.sup);
                end
            end
        end
    end

    task automatic drive(input logic [1:0] m, input logic hi, input logic lo, input logic bs);
        @(negedge clk);
        #1;
        mode_sel    = m;
        dm_above_hi = hi;
        dm_above_lo = lo;
        bsel_above  = bs;
    endtask

    task automatic clocks(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    task automatic expect_now(input string tag, input logic [1:0] st,
                              input logic [2:0] p, input logic sup);
        exp_t e;
        #1;
        e.tag = tag; e.st = st; e.paths = p; e.sup = sup;
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    // watchdog
    initial begin
        clocks(20000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clocks(3);
        #1 rst_n = 1'b1;
        // R2: reset state is automatic bias with internal supply
        expect_now("R2 reset bias", 2'b00, 3'b100, 1'b1);

        // R5: glitch shorter than the window is ignored
        drive(2'b00, 1'b0, 1'b1, 1'b0);
        clocks(DEB - 3);
        drive(2'b00, 1'b1, 1'b1, 1'b0);
        clocks(SETTLE);
        expect_now("R5 glitch ignored", 2'b00, 3'b100, 1'b1);

        // R5 boundary and R3 transition to short
        drive(2'b00, 1'b0, 1'b1, 1'b0);
        clocks(DEB - 1);
        expect_now("R5 not yet debounced", 2'b00, 3'b100, 1'b1);
        clocks(SETTLE);
        expect_now("R3 auto short, R7 supply off", 2'b01, 3'b010, 1'b0);

        // R4: DM below low restores bias; R3: below both stays bias
        drive(2'b00, 1'b0, 1'b0, 1'b0);
        clocks(SETTLE);
        expect_now("R4 restore bias", 2'b00, 3'b100, 1'b1);
        clocks(SETTLE);
        expect_now("R3 both low keeps bias", 2'b00, 3'b100, 1'b1);
        drive(2'b00, 1'b1, 1'b1, 1'b0);
        clocks(SETTLE);
        expect_now("R4 high keeps bias", 2'b00, 3'b100, 1'b1);

        // R6: external resistors turn internal supply off
        drive(2'b00, 1'b1, 1'b1, 1'b1);
        clocks(SETTLE);
        expect_now("R6 external bias", 2'b00, 3'b100, 1'b0);

        // R1/R8/R10: pass-through with exact gap timing
        drive(2'b11, 1'b1, 1'b1, 1'b1);
        clocks(3);
        expect_now("R10 pass status, old path held", 2'b10, 3'b100, 1'b0);
        expect_now("R8 all-off gap", 2'b10, 3'b000, 1'b0);
        expect_now("R8 pass path on", 2'b10, 3'b001, 1'b0);

        // R1: forced short ignoring comparators
        drive(2'b01, 1'b1, 1'b1, 1'b0);
        clocks(SETTLE);
        expect_now("R1 forced short", 2'b01, 3'b010, 1'b0);

        // R1/R7: forced bias with internal then external resistors
        drive(2'b10, 1'b0, 1'b1, 1'b0);
        clocks(SETTLE);
        expect_now("R1 forced bias R7 supply on", 2'b00, 3'b100, 1'b1);
        drive(2'b10, 1'b0, 1'b1, 1'b1);
        clocks(SETTLE);
        expect_now("R6 forced bias external", 2'b00, 3'b100, 1'b0);

        // R2: back to auto, short conditions held -> bias first, then short
        drive(2'b00, 1'b0, 1'b1, 1'b0);
        clocks(SETTLE);
        expect_now("R3 auto short again", 2'b01, 3'b010, 1'b0);

        // R9: leave auto immediately from short
        drive(2'b11, 1'b0, 1'b1, 1'b0);
        clocks(2);
        expect_now("R9 still short before sync", 2'b01, 3'b010, 1'b0);
        expect_now("R9 pass after three clocks", 2'b10, 3'b010, 1'b0);
        clocks(SETTLE);
        expect_now("R9 pass path", 2'b10, 3'b001, 1'b0);

        // R2: restart from bias on return to auto
        drive(2'b00, 1'b0, 1'b1, 1'b0);
        clocks(3);
        expect_now("R2 restart in bias", 2'b00, 3'b001, 1'b0);
        expect_now("R3 then short", 2'b01, 3'b000, 1'b0);
        clocks(SETTLE);
        expect_now("R3 short settled", 2'b01, 3'b010, 1'b0);

        // R8: overall path switching audit
        n_cmp++;
        if (bbm_viol != 0 || gap_seen == 0) begin
            n_bad++;
            $display("FAIL R8 switching audit: got violations=%0d gaps=%0d, expected 0 and >0",
                     bbm_viol, gap_seen);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule